// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port of up to 32 pins, reached through a small single-cycle register bus. Software sets an output value and a direction for each pin, and reads back the pad levels after they are brought into the clock domain. Each pin can also be programmed to flag an interrupt on a low level, a high level, a rising edge or a falling edge. A separate per-pin override flags it on both edges.

Flags collect in a sticky status register and are cleared by writing ones to it. A mask register gates the status onto two interrupt lines. One line serves the lower half of the pins and the other serves the upper half. Pad inputs pass through a two-stage synchronizer. Edges are found by comparing the synchronized level with its value one cycle earlier.

Top module: `gpio_irq_port`

## Requirements
- R1: The register offsets are: output data 0x00, direction 0x04, pin mode low half 0x0C, pin mode high half 0x10, mask 0x14 and both-edge select 0x1C. A value written to any of these reads back unchanged, and each of them reads 0 after reset.
- R2: The output data register reads back its stored value, never the pad level. pad_out equals that register and pad_oe equals the direction register, where 1 means driven.
- R3: Offset 0x08 returns the pad levels. A change made on pad_in before a clock edge is first visible there after the second rising edge. Writes to 0x08 change nothing.
- R4: Any offset above 0x1C, and any address that is not word aligned, reads 0. A write to such an address changes no register.
- R5: Each pin has a 2-bit mode field. Pin n uses bits [2*(n mod 16)+1 : 2*(n mod 16)] of the low-half register when n < 16, and of the high-half register otherwise. The encoding is 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge.
- R6: A rising-edge pin sets its status bit after a 0-to-1 pad change, and a falling-edge pin sets its bit after a 1-to-0 change. The opposite transition leaves the bit clear. The bit is set three rising edges after the pad_in change.
- R7: A level-mode pin sets its status bit on every cycle that its level condition holds. A clear written while the condition still holds leaves the bit set.
- R8: When a pin's bit in the both-edge register (0x1C) is 1, that pin flags both rising and falling edges whatever its mode field holds.
- R9: Writing to the status register (0x18) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: irq_lo is high exactly when some pin 0..15 has both its status and mask bits set, and irq_hi does the same for pins 16..31. After reset the mask is 0, so neither line rises even while status bits are set.
- R11: A status bit stays set after its trigger condition ends, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output value for each pin |
| pad_oe | output | 32 | Output enable for each pin |
| irq_lo | output | 1 | Interrupt for pins 0..15 |
| irq_hi | output | 1 | Interrupt for pins 16..31 |

## Verification
The assertions assume the bus is idle while reset is held. They also assume that each new pad level is held long enough to pass the synchronizer before it changes again, so that every detected edge matches a change in the synchronized pad value. The stimulus follows both rules. It drives every bus and pad input on the falling clock edge, keeps the bus quiet during reset, and holds each pad level for at least four cycles before it samples a result or changes the pad again.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Per-pin trigger encoding held in the mode registers
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_mode_e;

    localparam int unsigned REG_IDX_W = 3;
    localparam int unsigned WORD_LSB  = 2;

    // Word index of each register (byte offset / 4)
    typedef enum logic [REG_IDX_W-1:0] {
        REG_DOUT   = 3'd0,
        REG_DIR    = 3'd1,
        REG_PADS   = 3'd2,
        REG_CFG_LO = 3'd3,
        REG_CFG_HI = 3'd4,
        REG_MASK   = 3'd5,
        REG_STAT   = 3'd6,
        REG_BOTH   = 3'd7
    } reg_idx_e;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_stat,
    output logic [WIDTH-1:0] pad_prev
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;
    logic [WIDTH-1:0]             prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= '0;
        end else begin
            chain_q[0] <= pad_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign pad_stat = chain_q[STAGES-1];
    assign pad_prev = prev_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic       cur,
    input  logic       prev,
    input  logic       both_en,
    input  trig_mode_e mode,
    output logic       evt
);

    always_comb begin
        evt = 1'b0;
        if (both_en) begin
            evt = cur ^ prev;
        end else begin
            unique case (mode)
                TRIG_LOW:  evt = ~cur;
                TRIG_HIGH: evt = cur;
                TRIG_RISE: evt = cur & ~prev;
                TRIG_FALL: evt = ~cur & prev;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS   = 32,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_stat,
    input  logic [PINS-1:0]   evt,
    output logic [PINS-1:0]   dout_q,
    output logic [PINS-1:0]   dir_q,
    output logic [PINS-1:0]   cfg_lo_q,
    output logic [PINS-1:0]   cfg_hi_q,
    output logic [PINS-1:0]   mask_q,
    output logic [PINS-1:0]   stat_q,
    output logic [PINS-1:0]   both_q
);

    localparam int unsigned HIGH_LSB = WORD_LSB + REG_IDX_W;

    logic      in_map;
    logic      wr_hit;
    reg_idx_e  idx;
    logic [PINS-1:0] clr_vec;

    assign in_map = (bus_addr[ADDR_W-1:HIGH_LSB] == '0) && (bus_addr[WORD_LSB-1:0] == '0);
    assign idx    = reg_idx_e'(bus_addr[WORD_LSB +: REG_IDX_W]);
    assign wr_hit = bus_sel && bus_wr && in_map;
    assign clr_vec = (wr_hit && idx == REG_STAT) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q   <= '0;
            dir_q    <= '0;
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            mask_q   <= '0;
            both_q   <= '0;
        end else if (wr_hit) begin
            unique case (idx)
                REG_DOUT:   dout_q   <= bus_wdata;
                REG_DIR:    dir_q    <= bus_wdata;
                REG_CFG_LO: cfg_lo_q <= bus_wdata;
                REG_CFG_HI: cfg_hi_q <= bus_wdata;
                REG_MASK:   mask_q   <= bus_wdata;
                REG_BOTH:   both_q   <= bus_wdata;
                REG_PADS, REG_STAT: ;
            endcase
        end
    end

    // Status: a new detect wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | evt;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_map) begin
            unique case (idx)
                REG_DOUT:   bus_rdata = dout_q;
                REG_DIR:    bus_rdata = dir_q;
                REG_PADS:   bus_rdata = pad_stat;
                REG_CFG_LO: bus_rdata = cfg_lo_q;
                REG_CFG_HI: bus_rdata = cfg_hi_q;
                REG_MASK:   bus_rdata = mask_q;
                REG_STAT:   bus_rdata = stat_q;
                REG_BOTH:   bus_rdata = both_q;
            endcase
        end
    end

    // R11
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_q & ~clr_vec) & ~stat_q) == '0));

    // R9
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(clr_vec & ~evt) & stat_q) == '0));

    // R6
    status_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((stat_q & ~$past(stat_q)) & ~$past(evt)) == '0));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS        = 32,
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic              irq_lo,
    output logic              irq_hi
);

    localparam int unsigned HALF = PINS / 2;

    logic [PINS-1:0] pad_stat, pad_prev, evt_vec, edge_cfg;
    logic [PINS-1:0] dout_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, stat_q, both_q;
    logic [PINS-1:0] pending;
    trig_mode_e      pin_mode [PINS];

    gpio_pad_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .pad_stat (pad_stat),
        .pad_prev (pad_prev)
    );

    gpio_port_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_stat  (pad_stat),
        .evt       (evt_vec),
        .dout_q    (dout_q),
        .dir_q     (dir_q),
        .cfg_lo_q  (cfg_lo_q),
        .cfg_hi_q  (cfg_hi_q),
        .mask_q    (mask_q),
        .stat_q    (stat_q),
        .both_q    (both_q)
    );

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        if (n < HALF) begin : g_lo
            assign pin_mode[n] = trig_mode_e'(cfg_lo_q[2*n +: 2]);
        end else begin : g_hi
            assign pin_mode[n] = trig_mode_e'(cfg_hi_q[2*(n-HALF) +: 2]);
        end

        assign edge_cfg[n] = both_q[n] | cfg_bit_edge(pin_mode[n]);

        gpio_irq_detect u_det (
            .cur     (pad_stat[n]),
            .prev    (pad_prev[n]),
            .both_en (both_q[n]),
            .mode    (pin_mode[n]),
            .evt     (evt_vec[n])
        );
    end

    function automatic logic cfg_bit_edge(input trig_mode_e m);
        return (m == TRIG_RISE) || (m == TRIG_FALL);
    endfunction

    assign pad_out = dout_q;
    assign pad_oe  = dir_q;
    assign pending = stat_q & mask_q;
    assign irq_lo  = |pending[HALF-1:0];
    assign irq_hi  = |pending[PINS-1:HALF];

    // R6 R8
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((evt_vec & edge_cfg) & ~(pad_stat ^ $past(pad_stat))) == '0));

    // R10
    irq_lo_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> ((|mask_q[HALF-1:0]) && (|stat_q[HALF-1:0])));

    // R10
    irq_hi_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> ((|mask_q[PINS-1:HALF]) && (|stat_q[PINS-1:HALF])));

endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_lo, irq_hi;

    int tests = 0;
    int fails = 0;

    localparam logic [5:0] A_DOUT = 6'h00, A_DIR = 6'h04, A_PADS = 6'h08,
                           A_CFLO = 6'h0C, A_CFHI = 6'h10, A_MASK = 6'h14,
                           A_STAT = 6'h18, A_BOTH = 6'h1C;

    always #10 clk = ~clk;

    gpio_irq_port uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic stat_bit(input int b, output logic [31:0] v);
        logic [31:0] s;
        rd(A_STAT, s);
        v = {31'b0, s[b]};
    endtask

    task automatic t_reset();
        logic [31:0] v;
        wait_cyc(4);
        rd(A_DOUT, v); check("R1 dout reset", v, 32'h0);
        rd(A_DIR, v);  check("R1 dir reset", v, 32'h0);
        rd(A_CFLO, v); check("R1 cfg lo reset", v, 32'h0);
        rd(A_CFHI, v); check("R1 cfg hi reset", v, 32'h0);
        rd(A_MASK, v); check("R10 mask reset", v, 32'h0);
        rd(A_BOTH, v); check("R1 both reset", v, 32'h0);
        check("R2 oe reset", pad_oe, 32'h0);
        // all pins default to low-level mode with pads low
        rd(A_STAT, v); check("R7 status low level after reset", v, 32'hFFFF_FFFF);
        check("R10 no irq while masked", {30'b0, irq_hi, irq_lo}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        pad_in = 32'h5A5A_F0F0;
        wr(A_DOUT, 32'hA5A5_0F0F);
        wr(A_DIR, 32'hFFFF_0000);
        rd(A_DOUT, v); check("R2 dout readback not pads", v, 32'hA5A5_0F0F);
        check("R2 pad_out", pad_out, 32'hA5A5_0F0F);
        check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
        rd(A_DIR, v); check("R1 dir readback", v, 32'hFFFF_0000);
        wr(A_CFLO, 32'h1234_5678); rd(A_CFLO, v); check("R1 cfg lo readback", v, 32'h1234_5678);
        wr(A_CFHI, 32'h9ABC_DEF0); rd(A_CFHI, v); check("R1 cfg hi readback", v, 32'h9ABC_DEF0);
        wr(A_BOTH, 32'h0F0F_00FF); rd(A_BOTH, v); check("R1 both readback", v, 32'h0F0F_00FF);
        wr(A_MASK, 32'h8000_0001); rd(A_MASK, v); check("R1 mask readback", v, 32'h8000_0001);
        wr(A_MASK, 32'h0); wr(A_BOTH, 32'h0); wr(A_CFLO, 32'h0); wr(A_CFHI, 32'h0);
    endtask

    task automatic t_pads();
        logic [31:0] v;
        wait_cyc(4);
        rd(A_PADS, v); check("R3 pad status", v, 32'h5A5A_F0F0);
        pad_in = 32'h1234_5678;
        @(negedge clk);
        rd(A_PADS, v); check("R3 one edge later still old", v, 32'h5A5A_F0F0);
        @(negedge clk);
        rd(A_PADS, v); check("R3 two edges later new", v, 32'h1234_5678);
        wr(A_PADS, 32'hFFFF_FFFF);
        rd(A_PADS, v); check("R3 write ignored", v, 32'h1234_5678);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h01, 32'hFFFF_FFFF);
        rd(6'h20, v); check("R4 read 0x20", v, 32'h0);
        rd(6'h3C, v); check("R4 read 0x3C", v, 32'h0);
        rd(6'h01, v); check("R4 unaligned read", v, 32'h0);
        rd(A_DOUT, v); check("R4 write ignored dout", v, 32'hA5A5_0F0F);
        rd(A_MASK, v); check("R4 write ignored mask", v, 32'h0);
    endtask

    // pin3 rise(2), pin5 high(1), pin6 low(0); pin20 fall(3), pin25 rise(2) + both
    task automatic t_config();
        pad_in = 32'h0;
        wr(A_CFLO, (32'd2 << 6) | (32'd1 << 10));
        wr(A_CFHI, (32'd3 << 8) | (32'd2 << 18));
        wr(A_BOTH, 32'h1 << 25);
        wait_cyc(4);
        wr(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_edges();
        logic [31:0] v;
        stat_bit(3, v); check("R6 rise pin idle", v, 32'h0);
        pad_in[3] = 1'b1; wait_cyc(4);
        stat_bit(3, v); check("R6 rising edge sets pin3", v, 32'h1);
        wr(A_STAT, 32'h1 << 3);
        stat_bit(3, v); check("R9 clear pin3", v, 32'h0);
        pad_in[3] = 1'b0; wait_cyc(4);
        stat_bit(3, v); check("R6 falling ignored on rise pin", v, 32'h0);
        pad_in[20] = 1'b1; wait_cyc(4);
        stat_bit(20, v); check("R6 rising ignored on fall pin", v, 32'h0);
        pad_in[20] = 1'b0; wait_cyc(4);
        stat_bit(20, v); check("R6 R5 falling edge sets pin20", v, 32'h1);
    endtask

    task automatic t_levels();
        logic [31:0] v;
        stat_bit(5, v); check("R5 high pin idle", v, 32'h0);
        pad_in[5] = 1'b1; wait_cyc(4);
        stat_bit(5, v); check("R7 high level sets pin5", v, 32'h1);
        wr(A_STAT, 32'h1 << 5);
        stat_bit(5, v); check("R7 clear during level keeps set", v, 32'h1);
        pad_in[5] = 1'b0; wait_cyc(4);
        stat_bit(5, v); check("R11 sticky after level ends", v, 32'h1);
        wr(A_STAT, 32'h1 << 5); wait_cyc(2);
        stat_bit(5, v); check("R11 stays clear once condition gone", v, 32'h0);
        wr(A_STAT, 32'h1 << 6);
        stat_bit(6, v); check("R7 low level re-sets pin6", v, 32'h1);
    endtask

    task automatic t_both();
        logic [31:0] v;
        pad_in[25] = 1'b1; wait_cyc(4);
        stat_bit(25, v); check("R8 both-edge rising", v, 32'h1);
        wr(A_STAT, 32'h1 << 25);
        stat_bit(25, v); check("R9 clear pin25", v, 32'h0);
        pad_in[25] = 1'b0; wait_cyc(4);
        stat_bit(25, v); check("R8 both-edge falling overrides rise mode", v, 32'h1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(A_STAT, 32'hFFFF_FFFF);
        pad_in[3] = 1'b1; pad_in[25] = 1'b1; wait_cyc(4);
        rd(A_STAT, v); check("R9 two pins set", {30'b0, v[25], v[3]}, 32'h3);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R9 zero write no effect", {30'b0, v[25], v[3]}, 32'h3);
        wr(A_STAT, 32'h1 << 3);
        rd(A_STAT, v); check("R9 selective clear", {30'b0, v[25], v[3]}, 32'h2);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); check("R9 clear all edge pins", {30'b0, v[25], v[3]}, 32'h0);
    endtask

    task automatic t_irq();
        wr(A_MASK, (32'h1 << 3) | (32'h1 << 20));
        check("R10 no irq with nothing pending", {30'b0, irq_hi, irq_lo}, 32'h0);
        pad_in[3] = 1'b0; wait_cyc(4);
        pad_in[3] = 1'b1; wait_cyc(4);
        check("R10 irq_lo from pin3", {30'b0, irq_hi, irq_lo}, 32'h1);
        pad_in[20] = 1'b1; wait_cyc(4);
        pad_in[20] = 1'b0; wait_cyc(4);
        check("R10 both halves", {30'b0, irq_hi, irq_lo}, 32'h3);
        wr(A_STAT, 32'h1 << 3);
        check("R10 irq_lo drops on clear", {30'b0, irq_hi, irq_lo}, 32'h2);
        wr(A_MASK, 32'h0);
        check("R10 mask gates irq_hi", {30'b0, irq_hi, irq_lo}, 32'h0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_pads();
        t_unmapped();
        t_config();
        t_edges();
        t_levels();
        t_both();
        t_w1c();
        t_irq();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule